// File: doc/BRIEF.md
# Power-Fail Supervisor Sequencer

This block is a synchronous supervisor that follows the supply through three ordered degradation levels and drives the system's reaction to each one. Three comparator outputs arrive as digital flags: below the warning level, below the minimum operating level, and below the backup-switch level. Each flag passes through a multi-stage synchroniser. The block resolves the flags into one monotonic supply level. An enumerated state machine then decides between normal operation, early warning, supply-caused reset, backup, externally imposed reset and the power-on hold.

At the early-warning step the processor keeps running and, if enabled, gets one interrupt request at a fixed vector. A deeper drop holds the processor in reset and forces every chip enable and the write strobe inactive. In that state the block also pulls the shared open-drain reset line low. Another part can pull the same line low to put this block into reset too, which lets several parts go down together. The backup step also drops an active-low backup flag. On recovery, reset stays asserted for a fixed number of oscillator clocks before execution resumes.

States: `ST_RUN` (normal), `ST_WARN` (below warning, running), `ST_RESET` (below minimum, pad driven low), `ST_BACKUP` (below backup level, pad driven low), `ST_EXTRST` (shared line held low by another part), `ST_HOLD` (power-on delay). Transitions:
- From any state, a backup level goes to `ST_BACKUP`. Otherwise, from any state, a minimum level goes to `ST_RESET`.
- `ST_RUN`→`ST_WARN` on the warning level. `ST_WARN`→`ST_RUN` on a clear supply.
- `ST_RUN`, `ST_WARN` or `ST_HOLD`→`ST_EXTRST` when the line is seen low while not driven.
- `ST_RESET` or `ST_BACKUP`→`ST_HOLD` once the supply is above minimum.
- `ST_EXTRST`→`ST_HOLD` once the line is seen high.
- `ST_HOLD`→`ST_RUN` or `ST_WARN` (by level) after the hold count.

Top module: `pwr_supervisor`

## Requirements
- R1: The flags are resolved monotonically. A backup flag alone puts the block in backup. A minimum flag alone puts the block in reset, as if every higher flag were also set.
- R2: When the supply crosses into the warning level with `warn_en`=1, `warn_irq` goes to 1 and `cpu_rst` stays 0.
- R3: A warning crossing with `warn_en`=0 raises no interrupt.
- R4: `warn_irq` clears on `irq_ack`. It is not raised again while the supply stays below warning. It is raised again on the next crossing after the supply first returns to clear.
- R5: Below minimum, `cpu_rst`=1, `bus_inhibit`=1 and `rstn_oe`=1 (1 means the shared line is driven low).
- R6: Below the backup level, `bkp_n`=0 and the reset outputs of R5 also hold.
- R7: If the shared line reads low while the block is not driving it, the block sets `cpu_rst`=1 and `bus_inhibit`=1 with `rstn_oe`=0. After the line is released, the hold of R8 runs.
- R8: After the cause of reset goes away at a falling clock edge, `cpu_rst` reads 1 at HOLD_CYCLES+SYNC_STAGES consecutive falling edges (21506 with defaults), then reads 0.
- R9: `rst_in`=1 has the same effect as a minimum level and restarts the hold. After `rst_in` falls, `cpu_rst` stays 1 for exactly HOLD_CYCLES falling edges.
- R10: `warn_vector` reads 16'h002B. Entering any reset state clears a pending `warn_irq`.
- R11: Leaving the hold while the supply is still below warning enters the warning state without raising `warn_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_in | input | 1 | Active-high reset request, asynchronous assert |
| below_warn | input | 1 | Supply below warning level |
| below_min | input | 1 | Supply below minimum operating level |
| below_bkp | input | 1 | Supply below backup-switch level |
| warn_en | input | 1 | Enables the warning interrupt |
| irq_ack | input | 1 | Clears a pending warning interrupt |
| rstn_pin_in | input | 1 | Sensed level of the shared open-drain reset line |
| rstn_oe | output | 1 | 1 drives the shared reset line low |
| cpu_rst | output | 1 | Processor reset |
| bus_inhibit | output | 1 | Forces chip enables and write strobe inactive |
| bkp_n | output | 1 | 0 while on backup |
| warn_irq | output | 1 | Warning interrupt request |
| warn_vector | output | VEC_W | Interrupt vector address for the warning |

## Verification
The hardest case to reach is the shared reset line. It is both output and input, so the block must not mistake its own pull-down for another part's, both while it releases the line and after it does. The bench models the wired line as the AND of the block's drive and an external pull. It first leaves a supply-caused reset and checks that no spurious external reset follows. It then pulls the line from outside and measures the hold that follows its release. Restarting the hold with `rst_in` partway through a count is reached by pulsing `rst_in` a thousand cycles into a hold.

// File: rtl/pwr_sup_pkg.sv
package pwr_sup_pkg;
    typedef enum logic [1:0] {
        LVL_OK   = 2'd0,
        LVL_WARN = 2'd1,
        LVL_MIN  = 2'd2,
        LVL_BKP  = 2'd3
    } supply_lvl_e;

    typedef enum logic [2:0] {
        ST_RUN    = 3'd0,
        ST_WARN   = 3'd1,
        ST_RESET  = 3'd2,
        ST_BACKUP = 3'd3,
        ST_EXTRST = 3'd4,
        ST_HOLD   = 3'd5
    } pwr_state_e;
endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
    parameter int               WIDTH   = 4,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_in,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q_out
);
    logic [WIDTH-1:0] chain [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or posedge rst_in) begin
            if (rst_in)
                chain[g] <= RST_VAL;
            else if (g == 0)
                chain[g] <= d_in;
            else
                chain[g] <= chain[(g == 0) ? 0 : g-1];
        end
    end

    assign q_out = chain[STAGES-1];
endmodule

// File: rtl/pwr_level.sv
module pwr_level
    import pwr_sup_pkg::*;
(
    input  logic        below_warn,
    input  logic        below_min,
    input  logic        below_bkp,
    output supply_lvl_e lvl
);
    always_comb begin
        if (below_bkp)
            lvl = LVL_BKP;
        else if (below_min)
            lvl = LVL_MIN;
        else if (below_warn)
            lvl = LVL_WARN;
        else
            lvl = LVL_OK;
    end
endmodule

// File: rtl/pwr_hold_timer.sv
module pwr_hold_timer #(
    parameter int COUNT = 21504
) (
    input  logic clk,
    input  logic rst_in,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(COUNT + 1);
    localparam logic [CW-1:0] LAST = CW'(COUNT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or posedge rst_in) begin
        if (rst_in)
            cnt <= '0;
        else if (!run || cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign done = run && (cnt == LAST);
endmodule

// File: rtl/pwr_supervisor.sv
module pwr_supervisor
    import pwr_sup_pkg::*;
#(
    parameter int               SYNC_STAGES = 2,
    parameter int               HOLD_CYCLES = 21504,
    parameter int               VEC_W       = 16,
    parameter logic [VEC_W-1:0] WARN_VEC    = 16'h002B
) (
    input  logic             clk,
    input  logic             rst_in,
    input  logic             below_warn,
    input  logic             below_min,
    input  logic             below_bkp,
    input  logic             warn_en,
    input  logic             irq_ack,
    input  logic             rstn_pin_in,
    output logic             rstn_oe,
    output logic             cpu_rst,
    output logic             bus_inhibit,
    output logic             bkp_n,
    output logic             warn_irq,
    output logic [VEC_W-1:0] warn_vector
);
    localparam int GUARD = SYNC_STAGES + 1;
    localparam int GW    = $clog2(GUARD + 1);
    localparam logic [GW-1:0] GUARD_MAX = GW'(GUARD);

    logic [3:0]  raw_in, synced;
    supply_lvl_e lvl;
    pwr_state_e  state, next_state;
    logic        hold_done, pin_low_s, ext_low, supply_down, in_bkp;
    logic [GW-1:0] quiet;
    logic        irq_q;

    assign raw_in = {rstn_pin_in, below_bkp, below_min, below_warn};

    pwr_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1000)) u_sync (
        .clk(clk), .rst_in(rst_in), .d_in(raw_in), .q_out(synced)
    );

    pwr_level u_level (
        .below_warn(synced[0]), .below_min(synced[1]), .below_bkp(synced[2]),
        .lvl(lvl)
    );

    pwr_hold_timer #(.COUNT(HOLD_CYCLES)) u_timer (
        .clk(clk), .rst_in(rst_in), .run(state == ST_HOLD), .done(hold_done)
    );

    assign pin_low_s   = ~synced[3];
    assign supply_down = (lvl == LVL_MIN) || (lvl == LVL_BKP);
    assign in_bkp      = (lvl == LVL_BKP);

    // Own pull-down takes several cycles to leave the synchroniser: ignore the
    // sensed line until it has been released for GUARD cycles.
    always_ff @(posedge clk or posedge rst_in) begin
        if (rst_in)
            quiet <= '0;
        else if (rstn_oe)
            quiet <= '0;
        else if (quiet != GUARD_MAX)
            quiet <= quiet + 1'b1;
    end

    assign ext_low = pin_low_s && (quiet == GUARD_MAX);

    always_comb begin
        next_state = state;
        if (in_bkp)
            next_state = ST_BACKUP;
        else if (supply_down)
            next_state = ST_RESET;
        else begin
            unique case (state)
                ST_RUN: begin
                    if (ext_low)
                        next_state = ST_EXTRST;
                    else if (lvl == LVL_WARN)
                        next_state = ST_WARN;
                end
                ST_WARN: begin
                    if (ext_low)
                        next_state = ST_EXTRST;
                    else if (lvl == LVL_OK)
                        next_state = ST_RUN;
                end
                ST_RESET, ST_BACKUP: next_state = ST_HOLD;
                ST_EXTRST: begin
                    if (!pin_low_s)
                        next_state = ST_HOLD;
                end
                ST_HOLD: begin
                    if (ext_low)
                        next_state = ST_EXTRST;
                    else if (hold_done)
                        next_state = (lvl == LVL_WARN) ? ST_WARN : ST_RUN;
                end
                default: next_state = ST_RESET;
            endcase
        end
    end

    always_ff @(posedge clk or posedge rst_in) begin
        if (rst_in)
            state <= ST_RESET;
        else
            state <= next_state;
    end

    always_ff @(posedge clk or posedge rst_in) begin
        if (rst_in)
            irq_q <= 1'b0;
        else if (next_state != ST_RUN && next_state != ST_WARN)
            irq_q <= 1'b0;
        else if (state == ST_RUN && next_state == ST_WARN && warn_en)
            irq_q <= 1'b1;
        else if (irq_ack)
            irq_q <= 1'b0;
    end

    always_comb begin
        cpu_rst     = 1'b1;
        bus_inhibit = 1'b1;
        rstn_oe     = 1'b0;
        bkp_n       = 1'b1;
        unique case (state)
            ST_RUN, ST_WARN: begin
                cpu_rst     = 1'b0;
                bus_inhibit = 1'b0;
            end
            ST_RESET:  rstn_oe = 1'b1;
            ST_BACKUP: begin
                rstn_oe = 1'b1;
                bkp_n   = 1'b0;
            end
            ST_EXTRST, ST_HOLD: ;
            default: ;
        endcase
    end

    assign warn_irq    = irq_q;
    assign warn_vector = WARN_VEC;
endmodule

// File: rtl/pwr_supervisor_chk.sv
module pwr_supervisor_chk #(
    parameter int HOLD_CYCLES = 21504
) (
    input logic clk,
    input logic rst_in,
    input logic irq_ack,
    input logic rstn_oe,
    input logic cpu_rst,
    input logic bus_inhibit,
    input logic bkp_n,
    input logic warn_irq
);
    logic [31:0] rst_run;

    always_ff @(posedge clk or posedge rst_in) begin
        if (rst_in)
            rst_run <= '0;
        else if (rstn_oe || !cpu_rst)
            rst_run <= '0;
        else if (rst_run != 32'hFFFF_FFFF)
            rst_run <= rst_run + 1;
    end

    assert_drive_in_reset_R5: assert property (@(posedge clk) disable iff (rst_in)
        rstn_oe |-> (cpu_rst && bus_inhibit));

    assert_backup_drives_R6: assert property (@(posedge clk) disable iff (rst_in)
        !bkp_n |-> rstn_oe);

    assert_irq_while_running_R2: assert property (@(posedge clk) disable iff (rst_in)
        $rose(warn_irq) |-> !cpu_rst);

    assert_ack_clears_R4: assert property (@(posedge clk) disable iff (rst_in)
        (warn_irq && irq_ack && !$rose(warn_irq)) |=> !warn_irq);

    assert_hold_length_R8: assert property (@(posedge clk) disable iff (rst_in)
        $fell(cpu_rst) |-> (rst_run >= 32'(HOLD_CYCLES)));

    assert_reset_clears_irq_R10: assert property (@(posedge clk) disable iff (rst_in)
        $rose(cpu_rst) |-> !warn_irq);
endmodule

bind pwr_supervisor pwr_supervisor_chk #(.HOLD_CYCLES(HOLD_CYCLES)) u_chk (
    .clk(clk), .rst_in(rst_in), .irq_ack(irq_ack), .rstn_oe(rstn_oe),
    .cpu_rst(cpu_rst), .bus_inhibit(bus_inhibit), .bkp_n(bkp_n),
    .warn_irq(warn_irq)
);

// File: tb/pwr_supervisor_bench.sv
module pwr_supervisor_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD       = 21504;
    localparam int SYNC       = 2;
    localparam int NROWS      = 10;
    localparam logic [15:0] LONG = 16'(HOLD + 10);

    // {warn,min,bkp,en} {wait} {exp rst,oe,bkp_n,irq}
    localparam logic [23:0] VEC [NROWS] = '{
        {4'b0001, LONG,  4'b0010},
        {4'b1001, 16'd8, 4'b0011},
        {4'b1101, 16'd8, 4'b1110},
        {4'b1111, 16'd8, 4'b1100},
        {4'b0011, 16'd8, 4'b1100},
        {4'b1001, LONG,  4'b0010},
        {4'b0000, 16'd8, 4'b0010},
        {4'b1000, 16'd8, 4'b0010},
        {4'b0100, 16'd8, 4'b1110},
        {4'b0000, LONG,  4'b0010}
    };

    logic clk = 1'b0;
    logic rst_in = 1'b1;
    logic below_warn = 1'b0, below_min = 1'b0, below_bkp = 1'b0;
    logic warn_en = 1'b0, irq_ack = 1'b0, ext_pull = 1'b0;
    logic rstn_pin_in, rstn_oe, cpu_rst, bus_inhibit, bkp_n, warn_irq;
    logic [15:0] warn_vector;
    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    assign rstn_pin_in = ~(rstn_oe | ext_pull);

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_supervisor u_pwr_supervisor (
        .clk(clk), .rst_in(rst_in), .below_warn(below_warn),
        .below_min(below_min), .below_bkp(below_bkp), .warn_en(warn_en),
        .irq_ack(irq_ack), .rstn_pin_in(rstn_pin_in), .rstn_oe(rstn_oe),
        .cpu_rst(cpu_rst), .bus_inhibit(bus_inhibit), .bkp_n(bkp_n),
        .warn_irq(warn_irq), .warn_vector(warn_vector)
    );

    function automatic string row_tag(int r);
        case (r)
            0: return "R9";
            1: return "R2";
            2: return "R5";
            3: return "R6";
            4: return "R1";
            5: return "R11";
            7: return "R3";
            8: return "R1";
            default: return "R5";
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic count_reset(output int n);
        n = 0;
        while (cpu_rst && n < HOLD + 100) begin
            @(negedge clk);
            if (cpu_rst) n++;
        end
    endtask

    initial begin
        int n;
        cycles(3);
        // R9 R10: state while rst_in is held
        check("R9 reset outputs", {28'd0, cpu_rst, bus_inhibit, rstn_oe, warn_irq}, 32'hE);
        check("R10 vector", {16'd0, warn_vector}, 32'h002B);
        rst_in = 1'b0;

        for (int r = 0; r < NROWS; r++) begin
            {below_warn, below_min, below_bkp, warn_en} = VEC[r][23:20];
            cycles(int'(VEC[r][19:4]));
            check(row_tag(r),
                  {27'd0, cpu_rst, bus_inhibit, rstn_oe, bkp_n, warn_irq},
                  {27'd0, VEC[r][3], VEC[r][3], VEC[r][2], VEC[r][1], VEC[r][0]});
        end

        // R4: acknowledge, no re-raise while low, re-raise after clearing
        warn_en = 1'b1; below_warn = 1'b1;
        cycles(8);
        check("R4 raised", {31'd0, warn_irq}, 32'd1);
        irq_ack = 1'b1; cycles(1); irq_ack = 1'b0;
        cycles(1);
        check("R4 acked", {31'd0, warn_irq}, 32'd0);
        cycles(8);
        check("R4 no re-raise", {31'd0, warn_irq}, 32'd0);
        below_warn = 1'b0; cycles(8);
        below_warn = 1'b1; cycles(8);
        check("R4 new crossing", {31'd0, warn_irq}, 32'd1);
        irq_ack = 1'b1; cycles(1); irq_ack = 1'b0;
        below_warn = 1'b0; cycles(8);

        // R8: exact hold after a supply dip
        below_min = 1'b1; cycles(8);
        check("R8 in reset", {31'd0, cpu_rst}, 32'd1);
        below_min = 1'b0;
        count_reset(n);
        check("R8 hold length", 32'(n), 32'(HOLD + SYNC));
        cycles(10);
        check("R8 no false ext reset", {30'd0, cpu_rst, rstn_oe}, 32'd0);

        // R7: line pulled by another part
        ext_pull = 1'b1; cycles(8);
        check("R7 ext reset", {29'd0, cpu_rst, bus_inhibit, rstn_oe}, 32'h6);
        ext_pull = 1'b0;
        count_reset(n);
        check("R7 hold after release", 32'(n), 32'(HOLD + SYNC));

        // R9: rst_in restarts a running hold
        below_min = 1'b1; cycles(8);
        below_min = 1'b0; cycles(1000);
        rst_in = 1'b1; cycles(1); rst_in = 1'b0;
        count_reset(n);
        check("R9 hold restart", 32'(n), 32'(HOLD));

        $display("test done: total=%0d bad=%0d", total, bad);
        finished = 1'b1;
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 190000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule